// File: doc/BRIEF.md
# Half to single precision widener

This block turns a 16-bit IEEE 754 half-precision code into the 32-bit single-precision code for the same value. Every half value has an exact single equivalent, so no rounding takes place. Signed zeros, subnormals, normal numbers, infinities and NaNs are all covered. Half subnormals become normal single values. NaNs come out quiet and keep their payload bits.

A producer presents a code on `in_half` and raises `in_valid` for one cycle per item. Back-to-back items are accepted every cycle. The field decode, leading-one search and result assembly are combinational. One register stage then captures the result, so each result appears on `out_single` with `out_valid` exactly one clock later. While `in_valid` is low, the output register keeps its last value.

Top module: `h2s_convert`

## Requirements
- R1: Output bit 31 equals input bit 15 for every input code, including zeros, infinities and NaNs.
- R2: When input bits 14:0 are all zero, output bits 30:0 are all zero, which gives +0.0 or -0.0.
- R3: For an input exponent field (bits 14:10) between 1 and 30, the output exponent field (bits 30:23) is that value plus 112. Output bits 22:13 equal input bits 9:0, and output bits 12:0 are zero.
- R4: For an input exponent of 0 with a nonzero mantissa, let p be the position of the highest set mantissa bit (0 to 9). The output exponent is 103 + p. Output bits 22:13 hold the input mantissa shifted left by 10 - p and truncated to 10 bits, so the leading one is dropped. Output bits 12:0 are zero.
- R5: An input exponent of 31 with a zero mantissa gives output exponent 0xFF and output bits 22:0 all zero.
- R6: An input exponent of 31 with a nonzero mantissa gives output exponent 0xFF and output bit 22 set. Output bits 21:13 equal input bits 8:0, and output bits 12:0 are zero.
- R7: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high, and low otherwise. A synchronous active-high `rst` forces `out_valid` low at the next edge.
- R8: A clock edge that samples `in_valid` low leaves `out_single` unchanged, whatever value `in_half` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_half` as holding an item to convert |
| in_half | input | 16 | Half-precision code: sign bit 15, exponent bits 14:10, mantissa bits 9:0 |
| out_valid | output | 1 | Marks `out_single` as holding a new result |
| out_single | output | 32 | Single-precision code: sign bit 31, exponent bits 30:23, mantissa bits 22:0 |

## Verification
The properties assume that `in_half` is a known value whenever `in_valid` is high. They also assume that the clock edge after reset release is the first one at which a conversion counts. They make no assumption about `in_half` while `in_valid` is low. The stimulus drives all 65536 codes in ascending order with `in_valid` held high. Every 4096 items it inserts one idle cycle, during which it drives the bitwise inverse of the last code, to show that idle cycles do not change the output. The reset sequence holds `in_valid` high with a nonzero code so that reset clearing the valid flag is observable.

// File: rtl/h2s_pkg.sv
package h2s_pkg;

    localparam int H_EXP_W   = 5;
    localparam int H_MAN_W   = 10;
    localparam int S_EXP_W   = 8;
    localparam int S_MAN_W   = 23;
    localparam int H_W       = 1 + H_EXP_W + H_MAN_W;
    localparam int S_W       = 1 + S_EXP_W + S_MAN_W;
    localparam int H_BIAS    = (2 ** (H_EXP_W - 1)) - 1;
    localparam int S_BIAS    = (2 ** (S_EXP_W - 1)) - 1;
    localparam int EXP_ADJ   = S_BIAS - H_BIAS;
    localparam int MAN_SHIFT = S_MAN_W - H_MAN_W;
    localparam int SH_W      = $clog2(H_MAN_W + 1);

    typedef struct packed {
        logic               sign;
        logic [H_EXP_W-1:0] exp;
        logic [H_MAN_W-1:0] man;
    } half_t;

    typedef struct packed {
        logic               sign;
        logic [S_EXP_W-1:0] exp;
        logic [S_MAN_W-1:0] man;
    } single_t;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } h_class_e;

    // place a half mantissa at the top of a single mantissa
    function automatic logic [S_MAN_W-1:0] widen_man(input logic [H_MAN_W-1:0] m);
        return {m, {MAN_SHIFT{1'b0}}};
    endfunction

    // quiet bit of a single-precision mantissa
    function automatic logic [S_MAN_W-1:0] quiet_bit();
        logic [S_MAN_W-1:0] q;
        q = '0;
        q[S_MAN_W-1] = 1'b1;
        return q;
    endfunction

endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
    import h2s_pkg::*;
(
    input  half_t    h,
    output h_class_e cls
);
    logic exp_max;
    logic exp_min;
    logic man_nz;

    assign exp_max = &h.exp;
    assign exp_min = ~|h.exp;
    assign man_nz  = |h.man;

    always_comb begin
        if (exp_max) begin
            cls = man_nz ? CLS_NAN : CLS_INF;
        end else if (exp_min) begin
            cls = man_nz ? CLS_SUB : CLS_ZERO;
        end else begin
            cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/h2s_subnorm.sv
module h2s_subnorm #(
    parameter int MAN_W = 10,
    parameter int SHW   = $clog2(MAN_W + 1)
) (
    input  logic [MAN_W-1:0] man,
    output logic [SHW-1:0]   shift,
    output logic [MAN_W-1:0] frac
);
    logic [SHW-1:0] lead;

    // priority encoder: highest set bit wins
    always_comb begin
        lead = '0;
        for (int i = 0; i < MAN_W; i++) begin
            if (man[i]) begin
                lead = SHW'(i);
            end
        end
    end

    assign shift = SHW'(MAN_W) - lead;
    assign frac  = man << shift;
endmodule

// File: rtl/h2s_assemble.sv
module h2s_assemble
    import h2s_pkg::*;
(
    input  half_t           h,
    input  h_class_e        cls,
    input  logic [SH_W-1:0] shift,
    input  logic [H_MAN_W-1:0] frac,
    output single_t         s
);
    localparam logic [S_EXP_W-1:0] EXP_ALL1 = '1;
    localparam logic [S_EXP_W-1:0] SUB_BASE = S_EXP_W'(EXP_ADJ + 1);

    always_comb begin
        s.sign = h.sign;
        unique case (cls)
            CLS_ZERO: begin
                s.exp = '0;
                s.man = '0;
            end
            CLS_SUB: begin
                s.exp = SUB_BASE - S_EXP_W'(shift);
                s.man = widen_man(frac);
            end
            CLS_INF: begin
                s.exp = EXP_ALL1;
                s.man = '0;
            end
            CLS_NAN: begin
                s.exp = EXP_ALL1;
                s.man = widen_man(h.man) | quiet_bit();
            end
            default: begin
                s.exp = S_EXP_W'(h.exp) + S_EXP_W'(EXP_ADJ);
                s.man = widen_man(h.man);
            end
        endcase
    end
endmodule

// File: rtl/h2s_convert.sv
module h2s_convert
    import h2s_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [H_W-1:0] in_half,
    output logic           out_valid,
    output logic [S_W-1:0] out_single
);
    half_t             h;
    h_class_e          cls;
    logic [SH_W-1:0]   sub_shift;
    logic [H_MAN_W-1:0] sub_frac;
    single_t           nxt;
    single_t           res_q;

    assign h = half_t'(in_half);

    h2s_classify u_cls (
        .h   (h),
        .cls (cls)
    );

    h2s_subnorm #(
        .MAN_W (H_MAN_W),
        .SHW   (SH_W)
    ) u_sub (
        .man   (h.man),
        .shift (sub_shift),
        .frac  (sub_frac)
    );

    h2s_assemble u_asm (
        .h     (h),
        .cls   (cls),
        .shift (sub_shift),
        .frac  (sub_frac),
        .s     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            res_q <= nxt;
        end
    end

    assign out_single = res_q;
endmodule

// File: rtl/h2s_convert_chk.sv
module h2s_convert_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [15:0] in_half,
    input logic        out_valid,
    input logic [31:0] out_single
);
    // R1
    sign_copy_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_single[31] == $past(in_half[15]));

    // R2
    zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half[14:0] == 15'd0) |=> out_single[30:0] == 31'd0);

    // R3
    norm_exp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half[14:10] != 5'd0 && in_half[14:10] != 5'd31)
        |=> (out_single[30:23] == {3'b000, $past(in_half[14:10])} + 8'd112)
            && (out_single[22:13] == $past(in_half[9:0])));

    // R4
    sub_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half[14:10] == 5'd0 && in_half[9:0] != 10'd0)
        |=> (out_single[30:23] >= 8'd103) && (out_single[30:23] <= 8'd112)
            && (out_single[12:0] == 13'd0));

    // R5
    inf_out_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half[14:0] == 15'h7C00)
        |=> out_single[30:0] == 31'h7F80_0000);

    // R6
    nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half[14:10] == 5'd31 && in_half[9:0] != 10'd0)
        |=> (out_single[30:23] == 8'hFF) && out_single[22]
            && (out_single[21:13] == $past(in_half[8:0])));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_single));
endmodule

bind h2s_convert h2s_convert_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_half    (in_half),
    .out_valid  (out_valid),
    .out_single (out_single)
);

// File: tb/h2s_convert_tb.sv
`timescale 1ns/1ps
module h2s_convert_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic        out_valid;
    logic [31:0] out_single;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q [$];
    logic [15:0] src_q [$];
    logic [31:0] last_out;
    bit          have_last = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    h2s_convert u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_half    (in_half),
        .out_valid  (out_valid),
        .out_single (out_single)
    );

    // reference model: iterative normalisation, independent of the RTL
    function automatic logic [31:0] ref_conv(input logic [15:0] c);
        logic        s;
        logic [4:0]  e;
        logic [9:0]  m;
        logic [10:0] mm;
        int          k;
        s = c[15];
        e = c[14:10];
        m = c[9:0];
        if (e == 5'd31) begin
            return {s, 8'hFF, (m != 10'd0), m[8:0], 13'd0};
        end else if (e == 5'd0 && m == 10'd0) begin
            return {s, 31'd0};
        end else if (e == 5'd0) begin
            mm = {1'b0, m};
            k = 0;
            while (!mm[10]) begin
                mm = mm << 1;
                k++;
            end
            return {s, 8'(113 - k), mm[9:0], 13'd0};
        end
        return {s, 8'({3'b000, e} + 8'd112), m, 13'd0};
    endfunction

    function automatic string req_of(input logic [15:0] c);
        if (c[14:0] == 15'd0)       return "R2/R1";
        if (c[14:10] == 5'd0)       return "R4/R1";
        if (c[14:0] == 15'h7C00)    return "R5/R1";
        if (c[14:10] == 5'd31)      return "R6/R1";
        return "R3/R1";
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] c);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_half  = c;
        exp_q.push_back(ref_conv(c));
        src_q.push_back(c);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", {31'd0, out_valid}, 32'd0);
                end else begin
                    logic [31:0] e;
                    logic [15:0] c;
                    e = exp_q.pop_front();
                    c = src_q.pop_front();
                    check(out_single === e, req_of(c), out_single, e);
                end
                last_out  = out_single;
                have_last = 1'b1;
            end else if (have_last) begin
                // R8: idle edge leaves the result alone
                check(out_single === last_out, "R8", out_single, last_out);
            end
        end
    end

    initial begin
        // R7: reset clears out_valid even with in_valid high
        rst = 1'b1;
        in_valid = 1'b1;
        in_half = 16'h3C00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R7", {31'd0, out_valid}, 32'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R7", {31'd0, out_valid}, 32'd0);

        for (int c = 0; c < 65536; c++) begin
            push(16'(c));
            if ((c % 4096) == 4095) begin
                @(posedge clk);
                #1;
                in_valid = 1'b0;
                in_half  = ~16'(c);
            end
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7: every pushed item produced exactly one result
        check(exp_q.size() == 0, "R7", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule